// File: doc/BRIEF.md
# Vector Unsigned Compare Unit

This block is the execution slice for a single SIMD instruction: an unsigned "greater than" comparison across four 32-bit lanes of two 128-bit operands. Each cycle it can accept one instruction word together with both operands, which have already been read from the register file. It also takes the vector-enable status bit. The block decodes the word and checks that status bit. When the word is its instruction and vectors are enabled, one cycle later it presents a full-width lane mask and a destination register index with a write strobe. If the record bit is set, it also presents a 4-bit condition value with its own strobe.

When vectors are disabled, the block raises a one-cycle unavailable-exception pulse and produces no writes. A word that is not this instruction produces no writes and no exception. Instead, a not-handled pulse tells neighbouring units that the word is theirs to execute.

Top module: `vcmp_gtu_unit`

## Requirements
- R1: Each lane compares operand A with operand B as unsigned 32-bit numbers. A lane where A is strictly greater yields 0xFFFFFFFF in the mask. Every other lane yields 0x00000000, so equal lanes give zero, and values 0x80000000 and above rank above smaller values.
- R2: Lane 0 occupies bits [127:96] of the operands and the mask. Lane i occupies bits [127-32i : 96-32i].
- R3: When the record bit (instruction bit 21 counted from the MSB as bit 0, i.e. `instr[10]`) is 1, `cond_we` pulses and `cond_val` = {all_true, 0, all_false, 0}, MSB first. all_true is 1 only if every lane was true. all_false is 1 only if every lane was false.
- R4: When the record bit is 0, `cond_we` stays low and `cond_val` reads 0.
- R5: If `vec_en` is 0 for a matching word, `unavail_exc` pulses, and `dst_we` and `cond_we` stay low.
- R6: A word matches only when `instr[31:26]` equals 4 and `instr[9:0]` equals 646 (0x10000286 without the record bit, 0x10000686 with it). A valid non-matching word pulses `not_handled` with no writes and no exception.
- R7: All outputs are registered, one cycle after the `in_valid` cycle. Each strobe is high for exactly that one cycle, at most one of `dst_we`/`unavail_exc`/`not_handled` is high, and a cycle with `in_valid` low yields no strobe.
- R8: `dst_idx` carries `instr[25:21]` when `dst_we` is high. When `dst_we` is low, `dst_idx` and `out_mask` read 0.
- R9: Synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 128 | First source operand |
| opnd_b | input | 128 | Second source operand |
| vec_en | input | 1 | Vector facility enabled |
| out_mask | output | 128 | Per-lane all-ones/all-zeros result |
| dst_idx | output | 5 | Destination register index |
| dst_we | output | 1 | Destination write strobe |
| cond_val | output | 4 | Condition field value |
| cond_we | output | 1 | Condition field write strobe |
| unavail_exc | output | 1 | Vector-unavailable exception pulse |
| not_handled | output | 1 | Word is not this unit's instruction |

## Verification
The assertions check several rules on every cycle:
- strobes are mutually exclusive and vanish after an idle input cycle;
- every mask lane is uniform;
- the condition value never has both flags set or the padding bits set;
- the index and mask read zero whenever no write occurs.

Only the bench scenarios can show that the comparison itself is unsigned and strict, that lanes map to the right bit positions, and that the decoder rejects near-miss opcodes. The bench also shows which flag the all-true and all-false cases set.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
    localparam int LANES     = 4;
    localparam int LANE_W    = 32;
    localparam int VEC_W     = LANES * LANE_W;
    localparam int IDX_W     = 5;
    localparam int COND_W    = 4;
    localparam int PRIM_W    = 6;
    localparam int EXT_W     = 10;
    localparam logic [PRIM_W-1:0] PRIM_OPC = 6'd4;
    localparam logic [EXT_W-1:0]  EXT_OPC  = 10'd646;

    typedef enum logic [1:0] {
        K_IDLE    = 2'd0,
        K_EXEC    = 2'd1,
        K_UNAVAIL = 2'd2,
        K_FOREIGN = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             rec;
        logic [IDX_W-1:0] vrt;
    } dec_t;

    function automatic logic [COND_W-1:0] pack_cond(input logic at, input logic af);
        return {at, 1'b0, af, 1'b0};
    endfunction
endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
    import vcmp_pkg::*;
(
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic        vec_en,
    output dec_t        dec
);
    logic [9:0] unused_src_fields;
    logic       match;

    assign unused_src_fields = instr[20:11];
    assign match = (instr[31:26] == PRIM_OPC) && (instr[EXT_W-1:0] == EXT_OPC);

    always_comb begin
        dec.rec = instr[10];
        dec.vrt = instr[25:21];
        if (!in_valid)    dec.kind = K_IDLE;
        else if (!match)  dec.kind = K_FOREIGN;
        else if (!vec_en) dec.kind = K_UNAVAIL;
        else              dec.kind = K_EXEC;
    end
endmodule

// File: rtl/vcmp_lane_array.sv
module vcmp_lane_array
    import vcmp_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int W       = LANE_W,
    localparam int TOT_W  = N_LANES * W
) (
    input  logic [TOT_W-1:0] a,
    input  logic [TOT_W-1:0] b,
    output logic [TOT_W-1:0] mask,
    output logic             all_true,
    output logic             all_false
);
    logic [N_LANES-1:0] hit;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int HI = TOT_W - 1 - g * W;
        assign hit[g]           = a[HI -: W] > b[HI -: W];
        assign mask[HI -: W]    = {W{hit[g]}};
    end

    assign all_true  = &hit;
    assign all_false = ~|hit;
endmodule

// File: rtl/vcmp_retire.sv
module vcmp_retire
    import vcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [VEC_W-1:0]  mask_in,
    input  logic              all_true,
    input  logic              all_false,
    output logic [VEC_W-1:0]  out_mask,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              dst_we,
    output logic [COND_W-1:0] cond_val,
    output logic              cond_we,
    output logic              unavail_exc,
    output logic              not_handled
);
    logic exec;
    assign exec = (dec.kind == K_EXEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_mask    <= '0;
            dst_idx     <= '0;
            dst_we      <= 1'b0;
            cond_val    <= '0;
            cond_we     <= 1'b0;
            unavail_exc <= 1'b0;
            not_handled <= 1'b0;
        end else begin
            out_mask    <= exec ? mask_in : '0;
            dst_idx     <= exec ? dec.vrt : '0;
            dst_we      <= exec;
            cond_we     <= exec && dec.rec;
            cond_val    <= (exec && dec.rec) ? pack_cond(all_true, all_false) : '0;
            unavail_exc <= (dec.kind == K_UNAVAIL);
            not_handled <= (dec.kind == K_FOREIGN);
        end
    end
endmodule

// File: rtl/vcmp_gtu_unit.sv
module vcmp_gtu_unit
    import vcmp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   instr,
    input  logic [127:0]  opnd_a,
    input  logic [127:0]  opnd_b,
    input  logic          vec_en,
    output logic [127:0]  out_mask,
    output logic [4:0]    dst_idx,
    output logic          dst_we,
    output logic [3:0]    cond_val,
    output logic          cond_we,
    output logic          unavail_exc,
    output logic          not_handled
);
    dec_t             dec;
    logic [VEC_W-1:0] lane_mask;
    logic             at, af;

    vcmp_decode u_dec (
        .in_valid (in_valid),
        .instr    (instr),
        .vec_en   (vec_en),
        .dec      (dec)
    );

    vcmp_lane_array #(.N_LANES(LANES), .W(LANE_W)) u_lanes (
        .a         (opnd_a),
        .b         (opnd_b),
        .mask      (lane_mask),
        .all_true  (at),
        .all_false (af)
    );

    vcmp_retire u_ret (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .mask_in     (lane_mask),
        .all_true    (at),
        .all_false   (af),
        .out_mask    (out_mask),
        .dst_idx     (dst_idx),
        .dst_we      (dst_we),
        .cond_val    (cond_val),
        .cond_we     (cond_we),
        .unavail_exc (unavail_exc),
        .not_handled (not_handled)
    );
endmodule

// File: rtl/vcmp_gtu_chk.sv
module vcmp_gtu_chk
    import vcmp_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [127:0]  out_mask,
    input logic [4:0]    dst_idx,
    input logic          dst_we,
    input logic [3:0]    cond_val,
    input logic          cond_we,
    input logic          unavail_exc,
    input logic          not_handled
);
    function automatic logic uniform(input logic [VEC_W-1:0] m);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (m[i*LANE_W +: LANE_W] != '0 && m[i*LANE_W +: LANE_W] != '1) ok = 1'b0;
        end
        return ok;
    endfunction

    // R1
    lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        uniform(out_mask));

    // R3
    cond_shape_chk: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond_val[2] == 1'b0 && cond_val[0] == 1'b0 && !(cond_val[3] && cond_val[1])));

    // R3
    cond_needs_dst_chk: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> dst_we);

    // R4
    cond_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cond_we |-> cond_val == 4'd0);

    // R5
    unavail_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        unavail_exc |-> (!dst_we && !cond_we));

    // R6
    foreign_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        not_handled |-> (!dst_we && !cond_we && !unavail_exc));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dst_we, unavail_exc, not_handled}));

    // R7
    idle_nostrobe_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(dst_we || cond_we || unavail_exc || not_handled));

    // R8
    nowrite_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dst_we |-> (dst_idx == 5'd0 && out_mask == '0));
endmodule

bind vcmp_gtu_unit vcmp_gtu_chk u_chk (.*);

// File: tb/vcmp_gtu_unit_test.sv
`timescale 1ns/1ps
module vcmp_gtu_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] opnd_a = '0, opnd_b = '0;
    logic         vec_en = 1'b0;
    logic [127:0] out_mask;
    logic [4:0]   dst_idx;
    logic         dst_we, cond_we, unavail_exc, not_handled;
    logic [3:0]   cond_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [31:0] W_NOREC = 32'h1000_0286;
    localparam logic [31:0] W_REC   = 32'h1000_0686;

    always #5 clk = ~clk;

    vcmp_gtu_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .vec_en(vec_en),
        .out_mask(out_mask), .dst_idx(dst_idx), .dst_we(dst_we),
        .cond_val(cond_val), .cond_we(cond_we),
        .unavail_exc(unavail_exc), .not_handled(not_handled)
    );

    function automatic logic [31:0] lane_of(input logic [127:0] v, input int i);
        return v[127 - 32*i -: 32];
    endfunction

    function automatic logic [127:0] mk(input logic [31:0] l0, input logic [31:0] l1,
                                        input logic [31:0] l2, input logic [31:0] l3);
        return {l0, l1, l2, l3};
    endfunction

    // One clock: drive at negedge, compare all outputs at the next negedge
    task automatic step(input string req, input logic v, input logic [31:0] w,
                        input logic [127:0] a, input logic [127:0] b, input logic en);
        logic [127:0] e_mask;
        logic [4:0]   e_idx;
        logic         e_we, e_cwe, e_exc, e_nh;
        logic [3:0]   e_cond;
        bit match;
        int ntrue;
        e_mask = '0; e_idx = '0; e_we = 0; e_cwe = 0; e_exc = 0; e_nh = 0; e_cond = '0;
        match = (w[31:26] == 6'd4) && (w[9:0] == 10'd646);
        if (v) begin
            if (!match) e_nh = 1;
            else if (!en) e_exc = 1;
            else begin
                ntrue = 0;
                for (int i = 0; i < 4; i++) begin
                    if (longint'(lane_of(a, i)) > longint'(lane_of(b, i))) begin
                        ntrue++;
                        e_mask[127 - 32*i -: 32] = 32'hFFFF_FFFF;
                    end
                end
                e_we  = 1;
                e_idx = w[25:21];
                if (w[10]) begin
                    e_cwe  = 1;
                    e_cond = {ntrue == 4, 1'b0, ntrue == 0, 1'b0};
                end
            end
        end
        in_valid = v; instr = w; opnd_a = a; opnd_b = b; vec_en = en;
        @(negedge clk);
        checks++;
        if (out_mask !== e_mask || dst_idx !== e_idx || dst_we !== e_we ||
            cond_we !== e_cwe || cond_val !== e_cond || unavail_exc !== e_exc ||
            not_handled !== e_nh) begin
            errors++;
            $display("FAIL %s: got mask=%h idx=%0d we=%b cond=%b cwe=%b exc=%b nh=%b exp mask=%h idx=%0d we=%b cond=%b cwe=%b exc=%b nh=%b",
                     req, out_mask, dst_idx, dst_we, cond_val, cond_we, unavail_exc, not_handled,
                     e_mask, e_idx, e_we, e_cond, e_cwe, e_exc, e_nh);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if ({out_mask, dst_idx, dst_we, cond_val, cond_we, unavail_exc, not_handled} !== '0) begin
            errors++;
            $display("FAIL R9 reset: got mask=%h idx=%0d we=%b exp all zero", out_mask, dst_idx, dst_we);
        end
        rst = 1'b0;
        step("R7 idle", 0, W_REC, '1, '0, 1);
        // R1 equal lanes are false, all_false flag (R3)
        step("R1 equal", 1, W_REC | (32'd7 << 21), mk(32'h5, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000),
             mk(32'h5, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000), 1);
        // R1 unsigned ordering: high-bit values larger, all_true (R3)
        step("R1 unsigned", 1, W_REC | (32'd31 << 21),
             mk(32'h8000_0000, 32'hFFFF_FFFF, 32'h9000_0001, 32'h1),
             mk(32'h7FFF_FFFF, 32'h0, 32'h9000_0000, 32'h0), 1);
        // R2 lane mapping: only lane 0 true, mixed gives both flags 0 (R3)
        step("R2 lane0", 1, W_REC | (32'd3 << 21), mk(32'h2, 32'h1, 32'h1, 32'h1),
             mk(32'h1, 32'h1, 32'h1, 32'h1), 1);
        step("R2 lane3", 1, W_REC, mk(32'h0, 32'h0, 32'h0, 32'h10),
             mk(32'h1, 32'h1, 32'h1, 32'h0F), 1);
        step("R3 mixed", 1, W_REC, mk(32'hFFFF_FFFE, 32'h3, 32'h0, 32'h8000_0000),
             mk(32'hFFFF_FFFF, 32'h2, 32'h1, 32'h7FFF_FFFF), 1);
        // R4: record bit clear
        step("R4 norec", 1, W_NOREC | (32'd12 << 21), mk(32'h9, 32'h9, 32'h9, 32'h9), '0, 1);
        step("R4 norec false", 1, W_NOREC, '0, '1, 1);
        // R5: vector disabled
        step("R5 unavail", 1, W_REC | (32'd4 << 21), '1, '0, 0);
        step("R5 unavail norec", 1, W_NOREC, '1, '0, 0);
        // R6: near-miss words
        step("R6 bad prim", 1, W_REC ^ 32'h0400_0000, '1, '0, 1);
        step("R6 bad ext", 1, W_NOREC ^ 32'h0000_0001, '1, '0, 1);
        step("R6 bad ext novec", 1, W_NOREC + 32'd64, '1, '0, 0);
        // R7: back-to-back and idle after activity
        step("R7 b2b a", 1, W_REC | (32'd1 << 21), '1, '0, 1);
        step("R7 b2b b", 1, W_REC | (32'd2 << 21), '0, '1, 1);
        step("R7 idle after", 0, W_REC, '1, '0, 1);
        // R8: destination index field and source fields ignored
        step("R8 idx", 1, W_NOREC | (32'd21 << 21) | (32'h3FF << 11), mk(32'h1, 32'h0, 32'h1, 32'h0), '0, 1);
        // R9: reset mid-stream clears
        step("R8 pre", 1, W_REC, '1, '0, 1);
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if ({out_mask, dst_idx, dst_we, cond_val, cond_we, unavail_exc, not_handled} !== '0) begin
            errors++;
            $display("FAIL R9 mid reset: got mask=%h we=%b cwe=%b exp all zero", out_mask, dst_we, cond_we);
        end
        rst = 1'b0;
        step("R1 after reset", 1, W_REC, mk(32'h1, 32'h1, 32'h1, 32'h1), '0, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule